// File: doc/BRIEF.md
# Write completion status reporter

This block sits on the read path of a flash-style memory and decides what byte a host read returns while an internal erase or byte program is running. While the command sequencer reports an operation in progress, the normal array byte is replaced by a status byte. The host polls that byte to learn when the operation has finished. When the busy flag drops, the array byte is returned again unchanged.

Two polling schemes are carried in the status byte. The top bit is a complement poll. During a program it reads as the inverse of the top bit of the byte being written. During an erase it reads as 0, the inverse of the erased value. The next bit down is a toggle that flips once for every completed host read while the operation lasts. A host can detect completion in two ways: the top bit matches the written data, or two reads in a row return the same byte. Completion is not aligned to host reads, so a read that lands on the completion edge may mix status and data. Software confirms with two further reads.

Top module: `wcs_reporter`

## Requirements
- R1: While `busy_i` is low, `rd_data_o` equals `array_data_i` in every bit, including out of reset.
- R2: While `busy_i` is high and `op_i` is 1 (program), bit 7 of `rd_data_o` is the inverse of bit 7 of `last_data_i`.
- R3: While `busy_i` is high and `op_i` is 0 (erase), bit 7 of `rd_data_o` is 0.
- R4: While `busy_i` is high, bits 5 down to 0 of `rd_data_o` are 0 for both operation types.
- R5: While `busy_i` stays high, bit 6 of `rd_data_o` inverts in the cycle after each cycle in which `rd_strobe_i` is high, and holds its value across cycles with `rd_strobe_i` low.
- R6: In the first cycle of an operation (`busy_i` high after a low cycle), bit 6 reads 0. A strobe in that cycle counts, so the following read returns 1.
- R7: In the first cycle after `busy_i` falls, `rd_data_o` already carries the full array byte, so two consecutive reads of one address return identical bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Internal erase or program in progress |
| op_i | input | 1 | Operation type: 1 program, 0 erase |
| last_data_i | input | DATA_W | Byte most recently loaded for programming |
| array_data_i | input | DATA_W | Byte read from the memory array |
| rd_strobe_i | input | 1 | High for one cycle when a host read cycle completes |
| rd_data_o | output | DATA_W | Byte returned to the host |

## Verification
The bench builds the block with the default DATA_W of 8, so the complement poll is on bit 7 and the toggle is on bit 6, which matches the bench model's fixed bit positions. Random busy windows of one to twelve cycles, separated by idle gaps, produce several boundary cases. These are single-cycle operations, a strobe in the very cycle an operation starts, long runs without strobes, and operations that start again after one idle cycle. The random operation type and written byte cover both values of the polled bit.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  typedef enum logic {
    OP_ERASE = 1'b0,
    OP_PROG  = 1'b1
  } wcs_op_e;
endpackage

// File: rtl/wcs_toggle.sv
module wcs_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic rd_strobe_i,
  output logic tog_o
);
  logic busy_q, tog_q, start;

  assign start = busy_i && !busy_q;
  // value seen by the read in this cycle: fresh operations begin at 0
  assign tog_o = start ? 1'b0 : tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      busy_q <= busy_i;
      if (busy_i && rd_strobe_i) tog_q <= ~tog_o;
      else if (start)            tog_q <= 1'b0;
    end
  end

  // R5: strobed read during busy flips what the next read sees
  a_r5_flip_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && rd_strobe_i ##1 busy_i && busy_q |-> tog_o != $past(tog_o));
  // R5: no strobe, no change
  a_r5_hold_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !rd_strobe_i ##1 busy_i && busy_q |-> tog_o == $past(tog_o));
  // R6: first cycle of an operation reads 0
  a_r6_start_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i ##1 busy_i |-> !tog_o);
endmodule

// File: rtl/wcs_status_mux.sv
module wcs_status_mux
  import wcs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              busy_i,
  input  wcs_op_e           op_i,
  input  logic [DATA_W-1:0] last_data_i,
  input  logic [DATA_W-1:0] array_data_i,
  input  logic              tog_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  logic poll_bit;
  // erase polls against the erased value 1
  assign poll_bit = (op_i == OP_PROG) ? ~last_data_i[POLL_BIT] : 1'b0;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == POLL_BIT) begin : g_poll
      assign data_o[b] = busy_i ? poll_bit : array_data_i[b];
    end else if (b == TOG_BIT) begin : g_tog
      assign data_o[b] = busy_i ? tog_i : array_data_i[b];
    end else begin : g_zero
      assign data_o[b] = busy_i ? 1'b0 : array_data_i[b];
    end
  end
endmodule

// File: rtl/wcs_reporter.sv
module wcs_reporter
  import wcs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              op_i,
  input  logic [DATA_W-1:0] last_data_i,
  input  logic [DATA_W-1:0] array_data_i,
  input  logic              rd_strobe_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  logic    tog;
  wcs_op_e op;

  assign op = wcs_op_e'(op_i);

  wcs_toggle u_toggle (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy_i),
    .rd_strobe_i (rd_strobe_i),
    .tog_o       (tog)
  );

  wcs_status_mux #(.DATA_W(DATA_W)) u_mux (
    .busy_i       (busy_i),
    .op_i         (op),
    .last_data_i  (last_data_i),
    .array_data_i (array_data_i),
    .tog_i        (tog),
    .data_o       (rd_data_o)
  );

  a_r1_idle_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> rd_data_o == array_data_i);
  a_r2_prog_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && op_i |-> rd_data_o[POLL_BIT] != last_data_i[POLL_BIT]);
  a_r3_erase_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !op_i |-> !rd_data_o[POLL_BIT]);
  a_r4_low_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> rd_data_o[TOG_BIT-1:0] == '0);
  a_r5_toggle_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> rd_data_o[TOG_BIT] == tog);
  // R7: first idle cycle after busy already shows the array byte
  a_r7_handback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> rd_data_o == array_data_i);
endmodule

// File: tb/wcs_reporter_test.sv
module wcs_reporter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busy = 1'b0, op = 1'b0, strobe = 1'b0;
  logic [7:0] last_d = '0, arr_d = '0, rd_data;

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;
  logic m_tog = 1'b0, m_busy_prev = 1'b0;

  always #2 clk = ~clk;

  wcs_reporter #(.DATA_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .busy_i(busy), .op_i(op),
    .last_data_i(last_d), .array_data_i(arr_d),
    .rd_strobe_i(strobe), .rd_data_o(rd_data)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic b, input logic o,
                                          input logic [7:0] ld, input logic [7:0] ad,
                                          input logic t);
    if (!b) return ad;
    return {(o ? ~ld[7] : 1'b0), t, 6'b0};
  endfunction

  // one bus cycle: drive at negedge, sample 1 ns later, advance model
  task automatic step(input logic b, input logic o, input logic [7:0] ld,
                      input logic [7:0] ad, input logic st);
    logic start, eff;
    logic [7:0] e;
    @(negedge clk);
    busy = b; op = o; last_d = ld; arr_d = ad; strobe = st;
    #1;
    start = b && !m_busy_prev;
    eff   = start ? 1'b0 : m_tog;
    e     = exp_byte(b, o, ld, ad, eff);
    if (!b) begin
      chk(m_busy_prev ? "R7 handback" : "R1 idle passthrough", rd_data, e);
    end else begin
      chk(o ? "R2 program poll bit" : "R3 erase poll bit", {7'b0, rd_data[7]}, {7'b0, e[7]});
      chk(start ? "R6 toggle at start" : "R5 toggle bit", {7'b0, rd_data[6]}, {7'b0, e[6]});
      chk("R4 low bits zero", {2'b0, rd_data[5:0]}, {2'b0, e[5:0]});
    end
    if (b && st)    m_tog = ~eff;
    else if (start) m_tog = 1'b0;
    m_busy_prev = b;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state: idle passthrough
    step(0, 0, 8'h00, 8'h5A, 0);
    step(0, 1, 8'h00, 8'hA5, 1);
    // R2 program with top bit 1 and 0, R5 toggling per strobe
    step(1, 1, 8'h80, 8'hFF, 1);
    step(1, 1, 8'h80, 8'hFF, 0);
    step(1, 1, 8'h80, 8'hFF, 1);
    step(1, 1, 8'h80, 8'hFF, 1);
    step(0, 1, 8'h80, 8'h80, 0);
    step(0, 1, 8'h80, 8'h80, 1);
    step(1, 1, 8'h3C, 8'hFF, 0);
    step(1, 1, 8'h3C, 8'hFF, 1);
    step(0, 1, 8'h3C, 8'h3C, 1);
    // R3 erase, R6 strobe in the start cycle
    step(1, 0, 8'hFF, 8'h00, 1);
    step(1, 0, 8'hFF, 8'h00, 1);
    step(1, 0, 8'hFF, 8'h00, 0);
    step(0, 0, 8'hFF, 8'hFF, 1);
    step(0, 0, 8'hFF, 8'hFF, 1);
    // random operations separated by idle gaps
    for (int k = 0; k < 400; k++) begin
      automatic logic       o   = 1'($urandom);
      automatic logic [7:0] ld  = 8'($urandom);
      automatic int         len = 1 + int'($urandom % 12);
      automatic int         gap = 1 + int'($urandom % 3);
      for (int c = 0; c < len; c++) step(1, o, ld, 8'($urandom), 1'($urandom));
      for (int c = 0; c < gap; c++) step(0, 1'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule